// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Bus

This block is the two-wire serial (I2C) slave front end of a digitally controlled audio processor. A system clock samples SCL and SDA through synchronizers. The block detects START and STOP conditions and compares the 7-bit chip address in the first byte with its own. In a write transaction the byte after the address is a subaddress. Its low four bits load a register pointer and bit 4 selects whether that pointer advances. Every following data byte is written into a small control register file. In a read transaction the block sends a status byte that holds the zero-crossing-mute and soft-mute flags. It captures that byte again after every acknowledge from the master, so the master can poll the status without sending a new address.

One register is the mute register. Bit 0 of that register requests soft mute, and so does a low level on an external active-low mute pin. Bits 6..5 of the register form a zero-crossing window field, which is driven out to the analog path. The block drives SDA only to pull it low (`sda_oe` high means the line is pulled low). It does no clock stretching and supports only 7-bit addressing.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START, and it begins a new address phase at any point, abandoning the current transfer. A rising SDA while SCL is high is a STOP, and it returns the block to idle.
- R2: When bits 7..1 of the first byte equal `DEV_ADDR`, the block pulls SDA low for the whole ninth clock. On a mismatch it leaves SDA released until the next START.
- R3: Bit 0 of the address byte is 0 for a write. A write consists of the address byte, a subaddress byte and then data bytes. Every byte is 8 bits with the MSB first, and the block acknowledges each one.
- R4: Subaddress bits 3..0 load the register pointer. When subaddress bit 4 is 1, the pointer advances by one after each data byte.
- R5: When subaddress bit 4 is 0, every data byte of the transaction is written to the same register.
- R6: With auto-increment on, the pointer wraps from register `NREGS-1` to register 0.
- R7: A data byte sent while the pointer is at or above `NREGS` is acknowledged but changes no register.
- R8: Bit 0 of the address byte is 1 for a read. The block then sends a status byte MSB first. Bit 0 is soft mute active, bit 1 is zero-crossing mute active, and bits 7..2 are 0. SDA changes only while SCL is low.
- R9: After the master acknowledges (SDA low in the ninth clock), the block captures the status again and sends it as the next byte. After a master NACK it keeps SDA released until the next START.
- R10: `soft_mute_o` is 1 when bit 0 of register `MUTE_IDX` is 1 or when `mute_pin_n` is low.
- R11: `zc_window_o` equals bits 6..5 of register `MUTE_IDX`.
- R12: After reset, all registers read 0, SDA is released and `zc_window_o` is 0.
- R13: A STOP that arrives partway through a data byte discards the partial byte, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |
| mute_pin_n | input | 1 | External soft-mute request, active low |
| zc_muted_i | input | 1 | Zero-crossing mute active, from the audio path |
| soft_mute_o | output | 1 | Combined soft-mute request |
| zc_window_o | output | 2 | Zero-crossing window threshold field |
| regs_o | output | NREGS*8 | Control register contents, register n in bits 8n+7..8n |

## Verification
The assertions assume that SCL and SDA never change within the same synchronized sample. They also assume the master changes SDA only while SCL is low, except when it makes START or STOP, and that the master never issues a STOP while the slave is holding SDA low. The bench master holds each half of the bus clock for at least ten system clocks. It sets SDA in the middle of the low phase, and it sends START and STOP only while SDA is its own to drive. The bench samples the data line in the middle of the high phase, which is where the slave's acknowledge and read data must already be stable.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

  localparam int SUBPTR_W = 4;
  localparam int AINC_POS = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_e;

  function automatic logic addr_hit(input logic [6:0] rx_addr, input logic [6:0] own_addr);
    return rx_addr == own_addr;
  endfunction

  function automatic logic [SUBPTR_W-1:0] next_ptr(input logic [SUBPTR_W-1:0] ptr,
                                                   input int nregs);
    if (int'(ptr) == nregs - 1) return '0;
    return ptr + 1'b1;
  endfunction

  function automatic logic [7:0] status_byte(input logic soft_mute, input logic zc_mute);
    return {6'b000000, zc_mute, soft_mute};
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bus_events.sv
module bus_events #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [1:0] pair_s;
  logic       scl_d;
  logic       sda_d;

  sync_chain #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) sync_u (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (pair_s)
  );

  assign scl_s = pair_s[1];
  assign sda_s = pair_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] status_i,
  output logic       sda_drv,
  output logic [7:0] rx_byte,
  output logic       sub_stb,
  output logic       wr_stb
);

  localparam int CNT_W  = 4;
  localparam int BYTE_N = 8;

  phase_e           ph;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic             ack_ph;
  logic             rnw;
  logic             m_nack;
  logic             byte_full;

  assign byte_full = (int'(bit_cnt) == BYTE_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ack_ph  <= 1'b0;
      rnw     <= 1'b0;
      m_nack  <= 1'b1;
      sda_drv <= 1'b0;
      rx_byte <= '0;
      sub_stb <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      sub_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (stop_evt) begin
        ph      <= PH_IDLE;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_drv <= 1'b0;
      end else if (start_evt) begin
        ph      <= PH_ADDR;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_drv <= 1'b0;
      end else begin
        unique case (ph)
          PH_ADDR, PH_SUB, PH_WR: begin
            if (!ack_ph) begin
              if (scl_rise && !byte_full) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
              end else if (scl_fall && byte_full) begin
                bit_cnt <= '0;
                if (ph == PH_ADDR && !addr_hit(shreg[7:1], DEV_ADDR)) begin
                  ph <= PH_SKIP;
                end else begin
                  ack_ph  <= 1'b1;
                  sda_drv <= 1'b1;
                  rx_byte <= shreg;
                  if (ph == PH_ADDR) rnw <= shreg[0];
                  if (ph == PH_SUB)  sub_stb <= 1'b1;
                  if (ph == PH_WR)   wr_stb  <= 1'b1;
                end
              end
            end else if (scl_fall) begin
              ack_ph <= 1'b0;
              if (ph == PH_ADDR && rnw) begin
                ph      <= PH_RD;
                shreg   <= status_i;
                sda_drv <= ~status_i[7];
              end else begin
                sda_drv <= 1'b0;
                if (ph == PH_ADDR) ph <= PH_SUB;
                else               ph <= PH_WR;
              end
            end
          end
          PH_RD: begin
            if (!ack_ph) begin
              if (scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
              end else if (scl_fall) begin
                if (byte_full) begin
                  sda_drv <= 1'b0;
                  ack_ph  <= 1'b1;
                  bit_cnt <= '0;
                end else begin
                  shreg   <= {shreg[6:0], 1'b0};
                  sda_drv <= ~shreg[6];
                end
              end
            end else begin
              if (scl_rise) begin
                m_nack <= sda_s;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                if (m_nack) begin
                  ph      <= PH_SKIP;
                  sda_drv <= 1'b0;
                end else begin
                  shreg   <= status_i;
                  sda_drv <= ~status_i[7];
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (ph == PH_IDLE) && !sda_drv);

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ph == PH_ADDR) && (bit_cnt == '0));

  // R8
  sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv) |-> !scl_s);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drv |-> (ph != PH_SKIP) && (ph != PH_IDLE));

  // R3
  bit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= BYTE_N);

  // R3
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || sub_stb) |-> sda_drv);

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import audio_ctl_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_stb,
  input  logic             wr_stb,
  input  logic [7:0]       rx_byte,
  output logic [NREGS*8-1:0] regs_o
);

  logic [SUBPTR_W-1:0] ptr;
  logic                ainc;
  logic [7:0]          regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      ainc <= 1'b0;
    end else if (sub_stb) begin
      ptr  <= rx_byte[SUBPTR_W-1:0];
      ainc <= rx_byte[AINC_POS];
    end else if (wr_stb && ainc) begin
      ptr <= next_ptr(ptr, NREGS);
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (wr_stb && (int'(ptr) == g)) regs[g] <= rx_byte;
    end
    assign regs_o[g*8 +: 8] = regs[g];
  end

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ainc && (int'(ptr) == NREGS - 1)) |=> (ptr == '0));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ainc) |=> $stable(ptr));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ainc && (int'(ptr) < NREGS - 1)) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NREGS    = 8,
  parameter int         MUTE_IDX = 6,
  parameter int         STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               mute_pin_n,
  input  logic               zc_muted_i,
  output logic               soft_mute_o,
  output logic [1:0]         zc_window_o,
  output logic [NREGS*8-1:0] regs_o
);

  localparam int MUTE_LSB = MUTE_IDX * 8;

  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rx_byte;
  logic       sub_stb, wr_stb;
  logic [1:0] side_s;
  logic [7:0] status;
  logic [7:0] mute_reg;

  bus_events #(.STAGES(STAGES)) events_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  sync_chain #(.W(2), .STAGES(STAGES), .RST_VAL(2'b01)) side_sync_u (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({zc_muted_i, mute_pin_n}),
    .q     (side_s)
  );

  byte_engine #(.DEV_ADDR(DEV_ADDR)) engine_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .status_i  (status),
    .sda_drv   (sda_oe),
    .rx_byte   (rx_byte),
    .sub_stb   (sub_stb),
    .wr_stb    (wr_stb)
  );

  ctrl_regs #(.NREGS(NREGS)) regs_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .sub_stb (sub_stb),
    .wr_stb  (wr_stb),
    .rx_byte (rx_byte),
    .regs_o  (regs_o)
  );

  assign mute_reg    = regs_o[MUTE_LSB +: 8];
  assign soft_mute_o = mute_reg[0] | ~side_s[0];
  assign zc_window_o = mute_reg[6:5];
  assign status      = status_byte(soft_mute_o, side_s[1]);

  // R10
  pin_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(side_s[0]) |-> soft_mute_o);

endmodule

// File: tb/audio_ctl_i2c_slave_tb.sv
`timescale 1ns/1ps
module audio_ctl_i2c_slave_tb_top;

  localparam int   NREGS = 8;
  localparam int   Q     = 10;
  localparam logic [7:0] WADDR = 8'h88;
  localparam logic [7:0] RADDR = 8'h89;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic mute_pin_n = 1'b1;
  logic zc_in = 1'b0;
  logic sda_oe;
  logic soft_mute;
  logic [1:0] zc_win;
  logic [NREGS*8-1:0] regs;
  logic sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_r [NREGS];
  logic watch_oe = 1'b0;
  logic saw_oe = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  audio_ctl_i2c_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe      (sda_oe),
    .mute_pin_n  (mute_pin_n),
    .zc_muted_i  (zc_in),
    .soft_mute_o (soft_mute),
    .zc_window_o (zc_win),
    .regs_o      (regs)
  );

  always @(negedge clk) if (watch_oe && sda_oe) saw_oe <= 1'b1;

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = exp_r[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_status(input logic sm, input logic zm);
    logic [7:0] s;
    s = 8'h00;
    s[0] = sm;
    s[1] = zm;
    return s;
  endfunction

  task automatic i2c_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    ack = ~sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic rd_bits(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q);
      b[i] = sda_bus; wq(Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic m_ack(input logic nack);
    m_sda = nack; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                           input int nd, input string req);
    logic a;
    i2c_start();
    send_byte(WADDR, a); chk({req, " addr ack"}, 64'(a), 64'd1);
    send_byte(sub, a);   chk({req, " sub ack"}, 64'(a), 64'd1);
    send_byte(d0, a);    chk({req, " data ack"}, 64'(a), 64'd1);
    if (nd > 1) begin
      send_byte(d1, a);  chk({req, " data2 ack"}, 64'(a), 64'd1);
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R12 sda released", 64'(sda_oe), 64'd0);
    chk("R12 regs zero", regs, 64'd0);
    chk("R12 window zero", 64'(zc_win), 64'd0);
    chk("R10 no mute at reset", 64'(soft_mute), 64'd0);
  endtask

  task automatic t_autoinc();
    write_seq(8'h12, 8'hA5, 8'h3C, 2, "R3");
    exp_r[2] = 8'hA5; exp_r[3] = 8'h3C;
    chk("R4 auto-increment writes", regs, exp_flat());
  endtask

  task automatic t_fixed();
    write_seq(8'h05, 8'h11, 8'h33, 2, "R5");
    exp_r[5] = 8'h33;
    chk("R5 same register", regs, exp_flat());
  endtask

  task automatic t_wrap();
    write_seq(8'h17, 8'h55, 8'h66, 2, "R6");
    exp_r[7] = 8'h55; exp_r[0] = 8'h66;
    chk("R6 pointer wrap", regs, exp_flat());
  endtask

  task automatic t_outrange();
    write_seq(8'h0C, 8'h77, 8'h78, 2, "R7");
    chk("R7 out of range ignored", regs, exp_flat());
  endtask

  task automatic t_mismatch();
    logic a;
    saw_oe = 1'b0;
    watch_oe = 1'b1;
    i2c_start();
    send_byte(8'h8A, a); chk("R2 mismatch no ack", 64'(a), 64'd0);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    i2c_stop();
    watch_oe = 1'b0;
    chk("R2 sda never driven", 64'(saw_oe), 64'd0);
    chk("R2 regs untouched", regs, exp_flat());
  endtask

  task automatic t_mute();
    write_seq(8'h06, 8'h61, 8'h00, 1, "R11");
    exp_r[6] = 8'h61;
    wq(4);
    chk("R10 mute bit", 64'(soft_mute), 64'd1);
    chk("R11 window field", 64'(zc_win), 64'd3);
    write_seq(8'h06, 8'h40, 8'h00, 1, "R11");
    exp_r[6] = 8'h40;
    wq(4);
    chk("R10 mute cleared", 64'(soft_mute), 64'd0);
    chk("R11 window field 2", 64'(zc_win), 64'd2);
    mute_pin_n = 1'b0; wq(4);
    chk("R10 pin mute", 64'(soft_mute), 64'd1);
    mute_pin_n = 1'b1; wq(4);
    chk("R10 pin released", 64'(soft_mute), 64'd0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    mute_pin_n = 1'b0; zc_in = 1'b0; wq(4);
    i2c_start();
    send_byte(RADDR, a); chk("R8 read addr ack", 64'(a), 64'd1);
    rd_bits(b);          chk("R8 status byte 1", 64'(b), 64'(exp_status(1'b1, 1'b0)));
    mute_pin_n = 1'b1; zc_in = 1'b1; wq(4);
    m_ack(1'b0);
    rd_bits(b);          chk("R9 recaptured status", 64'(b), 64'(exp_status(1'b0, 1'b1)));
    mute_pin_n = 1'b0;
    m_ack(1'b1);
    saw_oe = 1'b0; watch_oe = 1'b1;
    rd_bits(b);
    watch_oe = 1'b0;
    chk("R9 released after nack", 64'(b), 64'hFF);
    chk("R9 no drive after nack", 64'(saw_oe), 64'd0);
    i2c_stop();
    mute_pin_n = 1'b1; zc_in = 1'b0;
  endtask

  task automatic t_abort();
    logic a;
    i2c_start();
    send_byte(WADDR, a);
    send_byte(8'h03, a);
    send_bits(8'hFF, 4);
    i2c_stop();
    chk("R13 partial byte dropped", regs, exp_flat());
    i2c_start();
    send_byte(WADDR, a);
    send_byte(8'h01, a);
    send_bits(8'hC3, 3);
    i2c_start();
    send_byte(WADDR, a); chk("R1 restart addr ack", 64'(a), 64'd1);
    send_byte(8'h01, a);
    send_byte(8'h5A, a);
    i2c_stop();
    exp_r[1] = 8'h5A;
    chk("R1 restart write", regs, exp_flat());
    write_seq(8'h03, 8'h99, 8'h00, 1, "R13");
    exp_r[3] = 8'h99;
    chk("R13 clean write after abort", regs, exp_flat());
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) exp_r[i] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_autoinc();
    t_fixed();
    t_wrap();
    t_outrange();
    t_mismatch();
    t_mute();
    t_read();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule